// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block moves data between two equal-width ports, A and B, in both directions at once. Each direction owns one storage element that can run in three modes. In transparent mode it passes its input straight to the far side. In hold mode it keeps its last value. In clocked mode it captures the input on a rising edge of that direction's own transfer clock. Each direction has its own set of four controls: a drive enable, a pass-through select, a transfer clock and a clock gate. The two sets are fully independent. A tri-stated output is shown as a data word plus a drive flag, so the block needs no real bidirectional pins.

Each input port has a keeper. A driver-valid flag comes with every input word. While the flag is high, the word goes to the storage path and is copied into the keeper on each system clock edge. While the flag is low, the storage path sees the keeper's copy instead, so an undriven bus never floats. The valid flag is the only qualifier on the data. There is no ready signal and no back-pressure: the far side always accepts, and a held or transparent output is simply presented.

The transfer clocks and all other controls are plain levels sampled by the system clock `clk`. A transfer-clock rising edge is a sample that is high at one system edge and was low at the previous system edge.

Top module: `dual_path_xcvr`

## Requirements
- R1: While a direction's pass-through select (`ab_le` / `ba_le`) is 1, its output data equals that direction's effective input (the live input word if its valid flag is 1, else the keeper copy) in the same cycle, with no clock edge in between.
- R2: While the pass-through select is 0 and no gated transfer-clock rising edge has been seen, the output data keeps its value across system clock edges, whatever the input does.
- R3: With the pass-through select at 0 and the clock gate (`*_ce_n`) at 0, a transfer-clock rising edge (sampled 0 at one `clk` edge and 1 at the next) stores the effective input seen at that second `clk` edge. The stored value appears on the output data right after that edge.
- R4: While the clock gate is 1, transfer-clock rising edges store nothing and the output data is unchanged.
- R5: A direction's drive flag is 1 exactly when its active-low drive enable (`*_oe_n`) is 0 and reset is released. The output data word is presented whatever the drive flag shows.
- R6: The A-to-B and B-to-A paths share no state. Activity on one direction's controls or input leaves the other direction's output data and drive flag unchanged.
- R7: While an input's valid flag is 0, that direction's effective input equals the last word that was present with the valid flag at 1 at a `clk` edge. This value is passed through in transparent mode and captured in clocked mode.
- R8: Pass-through takes priority over the transfer clock. When the select goes from 1 to 0, the stored value is the effective input sampled at the last `clk` edge while the select was still 1.
- R9: While `rst_n` is 0, both drive flags are 0, and the stored values and keepers are cleared to 0. After release, with the select at 0, each output data word reads 0 until something is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all controls |
| rst_n | input | 1 | Active-low synchronous clear of the stored values, keepers and edge history |
| a_in | input | W | Word driven onto port A from outside |
| a_in_vld | input | 1 | High while the outside driver actively drives port A |
| a_out | output | W | Word the block presents on port A (B-to-A path) |
| a_out_en | output | 1 | Block drives port A when high |
| b_in | input | W | Word driven onto port B from outside |
| b_in_vld | input | 1 | High while the outside driver actively drives port B |
| b_out | output | W | Word the block presents on port B (A-to-B path) |
| b_out_en | output | 1 | Block drives port B when high |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_le | input | 1 | A-to-B pass-through select |
| ab_clk | input | 1 | A-to-B transfer clock level |
| ab_ce_n | input | 1 | A-to-B transfer clock gate, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A pass-through select |
| ba_clk | input | 1 | B-to-A transfer clock level |
| ba_ce_n | input | 1 | B-to-A transfer clock gate, active low |

## Verification
A corrupted stored word shows up on the output as soon as that direction's select is low. It appears in the same cycle as the bad store, but stays hidden while pass-through is selected. A keeper holding the wrong copy stays invisible until the valid flag drops. From then on, the next cycle in transparent mode exposes it, and so does the next captured edge in clocked mode. A faulty edge history shows up as a missed or doubled capture: the output data either fails to change, or changes on a cycle where the transfer clock was held steady or gated off.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic le;
    logic tclk;
    logic ce_n;
  } lane_ctrl_t;

  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         din_vld,
  output logic [W-1:0] eff
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)       held <= '0;
    else if (din_vld) held <= din;
  end

  // Undriven port: the storage path sees the last driven word.
  assign eff = din_vld ? din : held;
endmodule

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk,
  input  logic ce_n,
  output logic fire
);
  logic tclk_q;

  // History starts high so a clock held high across reset is not an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) tclk_q <= 1'b1;
    else        tclk_q <= tclk;
  end

  assign fire = tclk & ~tclk_q & ~ce_n;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] eff,
  input  logic         le,
  input  logic         fire,
  output logic [W-1:0] q
);
  logic [W-1:0] stored;

  // Pass-through tracks the input every cycle and outranks the edge.
  always_ff @(posedge clk) begin
    if (!rst_n)    stored <= '0;
    else if (le)   stored <= eff;
    else if (fire) stored <= eff;
  end

  assign q = le ? eff : stored;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         din_vld,
  input  lane_ctrl_t   ctrl,
  output logic [W-1:0] dout,
  output logic         dout_en
);
  logic [W-1:0] eff;
  logic         fire;

  xcvr_keeper #(.W(W)) u_keep (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .din_vld (din_vld),
    .eff     (eff)
  );

  xcvr_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .tclk  (ctrl.tclk),
    .ce_n  (ctrl.ce_n),
    .fire  (fire)
  );

  xcvr_store #(.W(W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .eff   (eff),
    .le    (ctrl.le),
    .fire  (fire),
    .q     (dout)
  );

  assign dout_en = rst_n & ~ctrl.oe_n;
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_in_vld,
  output logic [W-1:0] a_out,
  output logic         a_out_en,
  input  logic [W-1:0] b_in,
  input  logic         b_in_vld,
  output logic [W-1:0] b_out,
  output logic         b_out_en,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_ce_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_ce_n
);
  logic [W-1:0] src      [NUM_DIR];
  logic         src_vld  [NUM_DIR];
  lane_ctrl_t   ctl      [NUM_DIR];
  logic [W-1:0] dst      [NUM_DIR];
  logic         dst_en   [NUM_DIR];

  assign src[DIR_AB]     = a_in;
  assign src_vld[DIR_AB] = a_in_vld;
  assign ctl[DIR_AB]     = '{oe_n: ab_oe_n, le: ab_le, tclk: ab_clk, ce_n: ab_ce_n};
  assign src[DIR_BA]     = b_in;
  assign src_vld[DIR_BA] = b_in_vld;
  assign ctl[DIR_BA]     = '{oe_n: ba_oe_n, le: ba_le, tclk: ba_clk, ce_n: ba_ce_n};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (src[d]),
      .din_vld (src_vld[d]),
      .ctrl    (ctl[d]),
      .dout    (dst[d]),
      .dout_en (dst_en[d])
    );
  end

  assign b_out    = dst[DIR_AB];
  assign b_out_en = dst_en[DIR_AB];
  assign a_out    = dst[DIR_BA];
  assign a_out_en = dst_en[DIR_BA];
endmodule

// File: rtl/xcvr_lane_chk.sv
module xcvr_lane_chk
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] din,
  input logic         din_vld,
  input lane_ctrl_t   ctrl,
  input logic [W-1:0] eff,
  input logic         fire,
  input logic [W-1:0] dout,
  input logic         dout_en
);
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.le |-> dout == eff); // R1

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ctrl.le && $past(!ctrl.le) && $past(!fire)) |-> $stable(dout)); // R2

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.le && fire) |=> (ctrl.le || dout == $past(eff))); // R3

  AST_KEEPER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !din_vld && $past(din_vld)) |-> eff == $past(din)); // R7

  AST_RESET_UNDRIVEN: assert property (@(posedge clk)
    !rst_n |-> !dout_en); // R9
endmodule

bind xcvr_lane xcvr_lane_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .din     (din),
  .din_vld (din_vld),
  .ctrl    (ctrl),
  .eff     (eff),
  .fire    (fire),
  .dout    (dout),
  .dout_en (dout_en)
);

// File: tb/test_dual_path_xcvr.sv
module test_dual_path_xcvr;
  localparam int W = 18;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_in_vld, b_in_vld, a_out_en, b_out_en;
  logic         ab_oe_n, ab_le, ab_clk, ab_ce_n;
  logic         ba_oe_n, ba_le, ba_clk, ba_ce_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dual_path_xcvr #(.W(W)) i_dual_path_xcvr (.*);

  // Row: {a_in[18], vld, le, tclk, ce_n, oe_n, exp_b_out[18], exp_b_en}
  localparam logic [41:0] VEC [NV] = '{
    {18'h00011, 5'b10000, 18'h00000, 1'b1},
    {18'h00022, 5'b10100, 18'h00000, 1'b1},
    {18'h00033, 5'b10100, 18'h00022, 1'b1},
    {18'h00044, 5'b10000, 18'h00022, 1'b1},
    {18'h00055, 5'b10110, 18'h00022, 1'b1},
    {18'h00066, 5'b10010, 18'h00022, 1'b1},
    {18'h00077, 5'b11100, 18'h00077, 1'b1},
    {18'h00088, 5'b11000, 18'h00088, 1'b1},
    {18'h00099, 5'b01000, 18'h00088, 1'b1},
    {18'h000AA, 5'b10000, 18'h00088, 1'b1},
    {18'h000BB, 5'b00100, 18'h00088, 1'b1},
    {18'h000CC, 5'b10101, 18'h000AA, 1'b0}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1:    return "R3";
      2, 3:    return "R2";
      4, 5:    return "R4";
      6, 7:    return "R1";
      8:       return "R7";
      9:       return "R8";
      10:      return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; a_in_vld = 1'b0; b_in = '0; b_in_vld = 1'b0;
    ab_oe_n = 1'b0; ab_le = 1'b0; ab_clk = 1'b0; ab_ce_n = 1'b0;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_clk = 1'b0; ba_ce_n = 1'b1;
    repeat (3) step();
    // R9: drive flag low during reset even with enable asserted
    chk("R9", {17'b0, b_out_en}, 18'h0);
    chk("R9", b_out, 18'h0);
    rst_n = 1'b1;
    #1;
    chk("R9", {17'b0, b_out_en}, 18'h1);
    chk("R9", b_out, 18'h0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      a_in     = v[41:24];
      a_in_vld = v[23];
      ab_le    = v[22];
      ab_clk   = v[21];
      ab_ce_n  = v[20];
      ab_oe_n  = v[19];
      #1;
      chk(row_tag(i), b_out, v[18:1]);
      chk("R5", {17'b0, b_out_en}, {17'b0, v[0]});
      step();
    end

    // R6: B-to-A side untouched by all A-to-B activity
    chk("R6", a_out, 18'h0);
    chk("R6", {17'b0, a_out_en}, 18'h0);

    // B-to-A clocked capture while A-to-B controls hold still
    b_in = 18'h12345; b_in_vld = 1'b1;
    ba_oe_n = 1'b0; ba_ce_n = 1'b0; ba_clk = 1'b0;
    step();
    ba_clk = 1'b1;
    #1;
    chk("R3", a_out, 18'h0);
    step();
    chk("R3", a_out, 18'h12345);
    chk("R5", {17'b0, a_out_en}, 18'h1);
    chk("R6", b_out, 18'h000AA);
    chk("R6", {17'b0, b_out_en}, 18'h0);

    // R8: clock edge while transparent, then select falls
    ba_clk = 1'b0;
    step();
    b_in = 18'h00F0F; ba_le = 1'b1; ba_clk = 1'b1;
    #1;
    chk("R8", a_out, 18'h00F0F);
    step();
    b_in = 18'h3A5A5; ba_le = 1'b0; ba_clk = 1'b1;
    #1;
    chk("R8", a_out, 18'h00F0F);
    step();
    chk("R8", a_out, 18'h00F0F);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule